// File: doc/BRIEF.md
# Tagged Word Access Guard

This block stands between a stack-oriented processor and its word store. Every stored word is 51 bits wide: a 48-bit payload in bits 47:0 and a 3-bit hardware tag in bits 50:48. The guard takes one request at a time over a valid/ready handshake. A request is a read or a write, and it carries a privilege flag, an operand-fetch flag, an address and a write word. The guard applies the tag rules to each request before the store is touched or the data is handed back.

Tag bit 48 marks a word as read-only. A store from user mode is suppressed, and flagged as a protection fault, when the word already in memory has an odd tag or when the new word has one. Privileged stores may write any tag. Reads return all 51 bits and a class code decoded from the tag. An operand fetch raises a fault on an uninitialized word, but only in user mode. An operand fetch that lands on a procedure entry word asks the processor to enter that procedure and reports the word's address. The backing store is a synchronous single-port RAM inside the block, so a write needs one read cycle to obtain the old tag before it can commit.

Top module: `tword_guard`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `wr_done`, `fault_prot`, `fault_uninit` and `enter_proc` are all 0.
- R2: A read accepted at a clock edge (`req_valid` and `req_ready` both 1, `req_write` 0) drives `rsp_valid` high for exactly the following cycle, and `rsp_rdata` then holds the full 51-bit word stored at `req_addr`.
- R3: During `rsp_valid`, `rsp_class` decodes the tag in bits 50:48 as follows: tag 0 gives 0 (single data), tag 2 gives 1 (double data), tag 4 gives 2 (step index), tag 6 gives 3 (empty/cut-back), tag 1 gives 4 (indirect reference), tag 3 gives 5 (code or stack control), tag 5 gives 6 (descriptor), and tag 7 gives 7 (procedure entry).
- R4: A privileged write (`req_priv` 1) always commits, whatever the tags are. `wr_done` is 1 and `fault_prot` is 0 in the cycle after acceptance, and a later read returns the new word.
- R5: A user write (`req_priv` 0) is suppressed when the stored word's bit 48 is 1. `fault_prot` and `wr_done` are 1 for exactly the cycle after acceptance, and the stored word is left unchanged.
- R6: A user write is suppressed in the same way when bit 48 of the new word is 1.
- R7: A user write where both the stored word and the new word have bit 48 equal to 0 commits, with `wr_done` 1 and `fault_prot` 0.
- R8: `fault_uninit` is 1 during `rsp_valid` exactly when the read was a user-mode operand fetch (`req_operand` 1, `req_priv` 0) of a word with tag 6. Privileged reads and non-operand reads of tag 6 give no fault.
- R9: `enter_proc` is 1 during `rsp_valid` exactly when the read was an operand fetch of a word with tag 7, in either mode. At that time `enter_addr` equals the address that was read.
- R10: Only one request is outstanding at a time. `req_ready` is 0 in the cycle after any acceptance and returns to 1 in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Guard can accept a request |
| req_write | input | 1 | 1 = store, 0 = read |
| req_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| req_operand | input | 1 | Read is an operand fetch (value use) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 51 | Word to store, tag in bits 50:48 |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 51 | Word read |
| rsp_class | output | 3 | Decoded class of the word read |
| fault_uninit | output | 1 | User operand fetch of an uninitialized word |
| enter_proc | output | 1 | Operand fetch hit a procedure entry word |
| enter_addr | output | ADDR_W | Address of that procedure entry word |
| wr_done | output | 1 | Write finished, whether it committed or not |
| fault_prot | output | 1 | User write suppressed by the tag rules |

## Verification
The assertions assume that every word read has been written since reset, because a RAM word that was never written has an undefined tag and neither the class nor the fault relations can hold for it. They also assume the requester offers at most one request at a time and does not count on a request being accepted while `req_ready` is low. The stimulus meets both assumptions. It first fills every address with a privileged write, and it issues each request only when the previous one has fully finished. It then sweeps every address against every new tag, in both privilege modes and with both fetch kinds.

// File: rtl/tword_pkg.sv
package tword_pkg;
  localparam int WORD_W = 51;
  localparam int DATA_W = 48;
  localparam int TAG_W  = WORD_W - DATA_W;
  localparam int CLS_W  = 3;

  localparam logic [TAG_W-1:0] TAG_EMPTY = 3'd6;
  localparam logic [TAG_W-1:0] TAG_ENTRY = 3'd7;

  localparam logic [CLS_W-1:0] CLS_SINGLE = 3'd0;
  localparam logic [CLS_W-1:0] CLS_DOUBLE = 3'd1;
  localparam logic [CLS_W-1:0] CLS_STEP   = 3'd2;
  localparam logic [CLS_W-1:0] CLS_EMPTY  = 3'd3;
  localparam logic [CLS_W-1:0] CLS_IREF   = 3'd4;
  localparam logic [CLS_W-1:0] CLS_CTRL   = 3'd5;
  localparam logic [CLS_W-1:0] CLS_DESC   = 3'd6;
  localparam logic [CLS_W-1:0] CLS_ENTRY  = 3'd7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WCHK = 2'd2
  } gstate_e;

  function automatic logic [CLS_W-1:0] tag_class(input logic [TAG_W-1:0] t);
    logic [CLS_W-1:0] c;
    case (t)
      3'd0:    c = CLS_SINGLE;
      3'd2:    c = CLS_DOUBLE;
      3'd4:    c = CLS_STEP;
      3'd6:    c = CLS_EMPTY;
      3'd1:    c = CLS_IREF;
      3'd3:    c = CLS_CTRL;
      3'd5:    c = CLS_DESC;
      default: c = CLS_ENTRY;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/tword_ram.sv
module tword_ram #(
  parameter int ADDR_W = 4,
  parameter int WIDTH  = 51,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/tword_rules.sv
module tword_rules
  import tword_pkg::*;
(
  input  logic             priv,
  input  logic             operand,
  input  logic [TAG_W-1:0] old_tag,
  input  logic [TAG_W-1:0] new_tag,
  output logic             wr_allow,
  output logic             uninit_hit,
  output logic             entry_hit,
  output logic [CLS_W-1:0] cls
);
  logic ro_old, ro_new;

  always_comb begin
    ro_old     = old_tag[0];
    ro_new     = new_tag[0];
    wr_allow   = priv | ~(ro_old | ro_new);
    uninit_hit = operand & ~priv & (old_tag == TAG_EMPTY);
    entry_hit  = operand & (old_tag == TAG_ENTRY);
    cls        = tag_class(old_tag);
  end
endmodule

// File: rtl/tword_ctrl.sv
module tword_ctrl
  import tword_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_priv,
  input  logic              req_operand,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic              wr_allow,
  output logic              req_ready,
  output logic              in_read,
  output logic              in_wchk,
  output logic              lat_priv,
  output logic              lat_operand,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [WORD_W-1:0] lat_wdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [WORD_W-1:0] ram_wdata
);
  logic [1:0]  rsync_q;
  logic        rst_int_n;
  gstate_e     st_q, st_d;
  logic        accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  always_comb begin
    req_ready = (st_q == ST_IDLE) & rst_int_n;
    accept    = req_valid & req_ready;
    in_read   = (st_q == ST_READ);
    in_wchk   = (st_q == ST_WCHK);
    st_d      = st_q;
    case (st_q)
      ST_IDLE: if (accept) st_d = req_write ? ST_WCHK : ST_READ;
      default: st_d = ST_IDLE;
    endcase
    ram_en    = accept | (in_wchk & wr_allow);
    ram_we    = in_wchk;
    ram_addr  = in_wchk ? lat_addr : req_addr;
    ram_wdata = lat_wdata;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) st_q <= ST_IDLE;
    else            st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      lat_priv    <= 1'b0;
      lat_operand <= 1'b0;
      lat_addr    <= '0;
      lat_wdata   <= '0;
    end else if (accept) begin
      lat_priv    <= req_priv;
      lat_operand <= req_operand & ~req_write;
      lat_addr    <= req_addr;
      lat_wdata   <= req_wdata;
    end
  end
endmodule

// File: rtl/tword_guard.sv
module tword_guard
  import tword_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_priv,
  input  logic              req_operand,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [50:0]       req_wdata,
  output logic              rsp_valid,
  output logic [50:0]       rsp_rdata,
  output logic [2:0]        rsp_class,
  output logic              fault_uninit,
  output logic              enter_proc,
  output logic [ADDR_W-1:0] enter_addr,
  output logic              wr_done,
  output logic              fault_prot
);
  logic              in_read, in_wchk, lat_priv, lat_operand;
  logic [ADDR_W-1:0] lat_addr, ram_addr;
  logic [WORD_W-1:0] lat_wdata, ram_wdata, ram_rdata;
  logic              ram_en, ram_we, wr_allow, uninit_hit, entry_hit;
  logic [CLS_W-1:0]  cls;

  tword_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_priv(req_priv), .req_operand(req_operand), .req_addr(req_addr),
    .req_wdata(req_wdata), .wr_allow(wr_allow), .req_ready(req_ready),
    .in_read(in_read), .in_wchk(in_wchk), .lat_priv(lat_priv),
    .lat_operand(lat_operand), .lat_addr(lat_addr), .lat_wdata(lat_wdata),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  tword_ram #(.ADDR_W(ADDR_W), .WIDTH(WORD_W)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_rdata)
  );

  tword_rules u_rules (
    .priv(lat_priv), .operand(lat_operand),
    .old_tag(ram_rdata[WORD_W-1:DATA_W]), .new_tag(lat_wdata[WORD_W-1:DATA_W]),
    .wr_allow(wr_allow), .uninit_hit(uninit_hit), .entry_hit(entry_hit), .cls(cls)
  );

  always_comb begin
    rsp_valid    = in_read;
    rsp_rdata    = ram_rdata;
    rsp_class    = cls;
    fault_uninit = in_read & uninit_hit;
    enter_proc   = in_read & entry_hit;
    enter_addr   = lat_addr;
    wr_done      = in_wchk;
    fault_prot   = in_wchk & ~wr_allow;
  end
endmodule

// File: rtl/tword_guard_chk.sv
module tword_guard_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              req_priv,
  input logic              rsp_valid,
  input logic [50:0]       rsp_rdata,
  input logic [2:0]        rsp_class,
  input logic              fault_uninit,
  input logic              enter_proc,
  input logic              wr_done,
  input logic              fault_prot
);
  // R10
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R2
  read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> (rsp_valid && !wr_done));
  // R2
  read_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R3
  ro_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_rdata[48]) |-> rsp_class[2]);
  // R4
  priv_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && req_priv) |=> (wr_done && !fault_prot));
  // R5
  prot_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_prot |-> (wr_done && !rsp_valid));
  // R6
  prot_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_prot |=> !fault_prot);
  // R8
  uninit_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_uninit |-> (rsp_valid && rsp_rdata[50:48] == 3'd6));
  // R9
  entry_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_proc |-> (rsp_valid && rsp_class == 3'd7));
endmodule

bind tword_guard tword_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_priv(req_priv), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_class(rsp_class), .fault_uninit(fault_uninit),
  .enter_proc(enter_proc), .wr_done(wr_done), .fault_prot(fault_prot)
);

// File: tb/tword_guard_bench.sv
module tword_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int NW = 1 << AW;

  logic          clk, rst_n;
  logic          req_valid, req_ready, req_write, req_priv, req_operand;
  logic [AW-1:0] req_addr, enter_addr;
  logic [50:0]   req_wdata, rsp_rdata;
  logic [2:0]    rsp_class;
  logic          rsp_valid, fault_uninit, enter_proc, wr_done, fault_prot;

  tword_guard #(.ADDR_W(AW)) u_tword_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_priv(req_priv), .req_operand(req_operand),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_class(rsp_class), .fault_uninit(fault_uninit),
    .enter_proc(enter_proc), .enter_addr(enter_addr), .wr_done(wr_done),
    .fault_prot(fault_prot)
  );

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;
  logic [50:0] model [NW];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_class(input logic [2:0] t);
    return {t[0], t[2:1]};
  endfunction

  function automatic logic [50:0] mkword(input int a, input int t, input int salt);
    logic [47:0] d;
    d = 48'(a) * 48'h0001_0203_0405 ^ 48'(salt) * 48'h0000_9E37_79B9;
    return {t[2:0], d};
  endfunction

  task automatic do_write(input int a, input logic [50:0] w, input bit priv,
                          output bit done, output bit prot, output bit rdy);
    req_valid = 1; req_write = 1; req_priv = priv; req_operand = 0;
    req_addr = AW'(a); req_wdata = w;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    done = wr_done; prot = fault_prot; rdy = req_ready;
    @(posedge clk); @(negedge clk);
    chk("R10 ready back after write", 64'(req_ready), 64'd1);
  endtask

  task automatic do_read(input int a, input bit priv, input bit oper,
                         output bit rv, output logic [50:0] rd, output logic [2:0] rc,
                         output bit fu, output bit ep, output logic [AW-1:0] ea, output bit rdy);
    req_valid = 1; req_write = 0; req_priv = priv; req_operand = oper;
    req_addr = AW'(a); req_wdata = '0;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    rv = rsp_valid; rd = rsp_rdata; rc = rsp_class; fu = fault_uninit;
    ep = enter_proc; ea = enter_addr; rdy = req_ready;
    @(posedge clk); @(negedge clk);
    chk("R2 rsp_valid one cycle", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    bit done, prot, rdy, rv, fu, ep;
    logic [50:0] rd, w;
    logic [2:0] rc;
    logic [AW-1:0] ea;
    req_valid = 0; req_write = 0; req_priv = 0; req_operand = 0;
    req_addr = '0; req_wdata = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 ready", 64'(req_ready), 64'd1);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 wr_done", 64'(wr_done), 64'd0);
    chk("R1 fault_prot", 64'(fault_prot), 64'd0);
    chk("R1 fault_uninit", 64'(fault_uninit), 64'd0);
    chk("R1 enter_proc", 64'(enter_proc), 64'd0);

    // R4 privileged fill, every tag including read-only ones
    for (int a = 0; a < NW; a++) begin
      w = mkword(a, a % 8, 1);
      do_write(a, w, 1, done, prot, rdy);
      model[a] = w;
      chk("R4 priv wr_done", 64'(done), 64'd1);
      chk("R4 priv no fault", 64'(prot), 64'd0);
      chk("R10 ready low after write", 64'(rdy), 64'd0);
    end
    // R2 R3 plain reads
    for (int a = 0; a < NW; a++) begin
      do_read(a, 0, 0, rv, rd, rc, fu, ep, ea, rdy);
      chk("R2 rsp_valid", 64'(rv), 64'd1);
      chk("R2 rdata", 64'(rd), 64'(model[a]));
      chk("R3 class", 64'(rc), 64'(exp_class(model[a][50:48])));
      chk("R8 no uninit on plain read", 64'(fu), 64'd0);
      chk("R9 no enter on plain read", 64'(ep), 64'd0);
      chk("R10 ready low after read", 64'(rdy), 64'd0);
    end

    // R5 R6 R7 user writes: every address against every new tag
    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < NW; a++) begin
        for (int t = 0; t < 8; t++) begin
          bit allow;
          w = mkword(a, t, 7 + pass * 8 + t);
          allow = !model[a][48] && !w[48];
          do_write(a, w, 0, done, prot, rdy);
          chk("R5 R6 R7 user wr_done", 64'(done), 64'd1);
          if (model[a][48])  chk("R5 stored ro -> fault", 64'(prot), 64'd1);
          else if (w[48])    chk("R6 new ro -> fault", 64'(prot), 64'd1);
          else               chk("R7 even tags commit", 64'(prot), 64'd0);
          if (allow) model[a] = w;
          do_read(a, 1, 0, rv, rd, rc, fu, ep, ea, rdy);
          if (allow) chk("R7 committed word", 64'(rd), 64'(model[a]));
          else       chk("R5 R6 memory unchanged", 64'(rd), 64'(model[a]));
          chk("R3 class after user write", 64'(rc), 64'(exp_class(model[a][50:48])));
        end
        // restore a spread of tags via privileged writes for the second pass
        w = mkword(a, (a + 3) % 8, 99);
        do_write(a, w, 1, done, prot, rdy);
        model[a] = w;
        chk("R4 priv overwrite", 64'(prot), 64'd0);
      end
    end

    // R8 R9 operand fetches in both modes
    for (int a = 0; a < NW; a++) begin
      for (int t = 0; t < 8; t++) begin
        w = mkword(a, t, 200 + t);
        do_write(a, w, 1, done, prot, rdy);
        model[a] = w;
        for (int m = 0; m < 4; m++) begin
          bit priv, oper;
          priv = m[0]; oper = m[1];
          do_read(a, priv, oper, rv, rd, rc, fu, ep, ea, rdy);
          chk("R2 rdata in fetch sweep", 64'(rd), 64'(w));
          chk("R8 uninit", 64'(fu), 64'(oper && !priv && t == 6));
          chk("R9 enter", 64'(ep), 64'(oper && t == 7));
          if (oper && t == 7) chk("R9 enter_addr", 64'(ea), 64'(a));
        end
      end
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule